// File: doc/BRIEF.md
# Serial Wire Debug Target Engine

This block is the target end of a two-wire serial debug link. It runs on the serial clock itself and samples the shared data line once per rising edge. It sees that line as `swd_in` and drives it through `swd_out` with the enable `swd_oe`. The host sends an 8-bit request. The engine releases the line for one turnaround bit and then answers with a 3-bit acknowledge. After that it either returns a 32-bit word with its parity bit or takes in a word from the host.

The engine follows the state of the line itself. A long run of high bits puts it into a line-reset state. It leaves that state only after two low bits. From then on every access is refused with FAULT until the host has read the fixed identification word. This word sits at debug-port register 0 and is set by a parameter. Every other access goes to an internal register file through a one-cycle read strobe or write strobe. The register file signals whether it is ready when the request completes.

Top module: `swd_target_engine`

## Requirements
- R1: While `rst` is high, and on the first edge after it, the engine does not drive the line, `reg_rd` and `reg_wr` stay low, `err_sticky` is clear, and the engine sits in the line-reset state with the identification lock set.
- R2: When more than `RESET_HIGH` consecutive high samples arrive (default 50), the engine returns to the line-reset state and sets the lock again. A run of exactly `RESET_HIGH` highs changes neither the lock nor the link state.
- R3: In the line-reset state the engine accepts no request until it has seen two consecutive low samples. A high sample in that state restarts the count of lows.
- R4: A request is 8 bits sent least significant bit first, in this order: start=1, port select (0 = debug port, 1 = access port), read flag (1 = read), A2, A3, parity, stop=0, park=1. The parity bit equals the XOR of port select, read flag, A2 and A3. A request with wrong parity, a stop bit of 1 or a park bit of 0 gets no response, and the engine waits for the next start bit.
- R5: After a valid request the line stays undriven for exactly one bit. The target then drives three acknowledge bits in this order on the wire: OK = 1,0,0; WAIT = 0,1,0; FAULT = 0,0,1.
- R6: While the lock is set, every transaction gets FAULT except a debug-port read of address 0. That read gets OK, returns `ID_VALUE`, and clears the lock.
- R7: An OK read is followed at once by 32 data bits, least significant bit first, then one parity bit equal to the XOR of the data, then one undriven turnaround bit. A debug-port read of address 0 returns `ID_VALUE`. Any other read pulses `reg_rd` for the turnaround bit after the request and returns `reg_rdata` as sampled at the end of that bit.
- R8: An OK write is followed by one undriven turnaround bit. The host then sends 32 data bits, least significant bit first, and a parity bit. If the parity is correct, `reg_wr` pulses for one cycle with `reg_ap`, `reg_addr` and `reg_wdata` holding the access.
- R9: A write whose data parity is wrong produces no `reg_wr` and sets `err_sticky`. The flag stays set until `rst`.
- R10: When the lock is clear and the access is not the identification read, a low `reg_ready` at the final request bit gives WAIT, and no strobe is issued.
- R11: After WAIT or FAULT the engine releases the line for one turnaround bit. It skips the data phase and accepts the next request that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; the line is sampled on the rising edge |
| rst | input | 1 | Synchronous active-high power-on reset |
| swd_in | input | 1 | Sampled value of the data line |
| swd_out | output | 1 | Value the target drives onto the line |
| swd_oe | output | 1 | High while the target drives the line |
| reg_ready | input | 1 | Register file can take the access now |
| reg_rdata | input | DW | Read data from the register file |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_ap | output | 1 | Port select of the current access |
| reg_addr | output | 2 | Register address {A3, A2} of the current access |
| reg_wdata | output | DW | Write data, valid with `reg_wr` |
| err_sticky | output | 1 | Set by a write with bad data parity |

## Verification
The bench builds the engine with its default parameters: a 32-bit data word, the identification value 0x2BA01477, and a line-reset threshold of 50. Keeping the threshold at its real value lets the bench send runs of exactly 50 and of 51 high bits. It can then tell a run that just fails to reset the link from one that just succeeds. Because the word width stays at 32, the whole acknowledge and parity framing is exercised end to end, together with the bit-exact identification value.

// File: rtl/swdt_pkg.sv
package swdt_pkg;
  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE, ST_REQ, ST_TRN_REQ, ST_ACK,
    ST_RDATA, ST_TRN_WR, ST_WDATA, ST_TRN_END
  } swdt_state_e;

  // acknowledge codes, bit 0 goes out first
  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;

  typedef struct packed {
    logic       ap;
    logic       rnw;
    logic [1:0] addr;
  } swdt_req_t;
endpackage

// File: rtl/swdt_line_mon.sv
module swdt_line_mon #(
  parameter int RESET_HIGH = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic line,
  output logic line_rst
);
  localparam int HW = $clog2(RESET_HIGH + 1);
  localparam logic [HW-1:0] LIMIT = HW'(RESET_HIGH);

  logic [HW-1:0] hicnt;

  always_ff @(posedge clk) begin
    if (rst || !line) hicnt <= '0;
    else if (hicnt != LIMIT) hicnt <= hicnt + 1'b1;
  end

  // fires on the sample that makes the run longer than RESET_HIGH
  assign line_rst = line && (hicnt == LIMIT);

  assert_run_high_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(line_rst) |-> $past(line));
endmodule

// File: rtl/swdt_req_dec.sv
module swdt_req_dec
  import swdt_pkg::*;
(
  input  logic [7:0] word,
  output logic       ok,
  output swdt_req_t  req
);
  always_comb begin
    req.ap   = word[1];
    req.rnw  = word[2];
    req.addr = {word[4], word[3]};
    ok = word[0] && (word[5] == ^word[4:1]) && !word[6] && word[7];
  end
endmodule

// File: rtl/swd_target_engine.sv
module swd_target_engine
  import swdt_pkg::*;
#(
  parameter logic [31:0] ID_VALUE   = 32'h2BA01477,
  parameter int          RESET_HIGH = 50,
  parameter int          DW         = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          swd_in,
  output logic          swd_out,
  output logic          swd_oe,
  input  logic          reg_ready,
  input  logic [DW-1:0] reg_rdata,
  output logic          reg_rd,
  output logic          reg_wr,
  output logic          reg_ap,
  output logic [1:0]    reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          err_sticky
);
  localparam int CW = $clog2(DW + 2);
  localparam logic [CW-1:0] LAST = CW'(DW);
  localparam logic [DW-1:0] ID_W = DW'(ID_VALUE);

  swdt_state_e st;
  logic [CW-1:0] bcnt;
  logic [6:0]    rsh;
  logic [DW:0]   dsh;
  logic [2:0]    ack, nxt_ack;
  logic          locked, is_id, rnw_q, low1, line_rst, dec_ok, id_hit;
  logic [7:0]    word;
  logic [DW:0]   wfull;
  swdt_req_t     dq;

  assign word  = {swd_in, rsh};
  assign wfull = {swd_in, dsh[DW:1]};

  swdt_line_mon #(.RESET_HIGH(RESET_HIGH)) u_mon (
    .clk(clk), .rst(rst), .line(swd_in), .line_rst(line_rst));

  swdt_req_dec u_dec (.word(word), .ok(dec_ok), .req(dq));

  always_comb begin
    id_hit = !dq.ap && dq.rnw && (dq.addr == 2'd0);
    if (locked && !id_hit)        nxt_ack = ACK_FAULT;
    else if (!id_hit && !reg_ready) nxt_ack = ACK_WAIT;
    else                          nxt_ack = ACK_OK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_RESET; bcnt <= '0; rsh <= '0; dsh <= '0; ack <= '0;
      locked <= 1'b1; is_id <= 1'b0; rnw_q <= 1'b0; low1 <= 1'b0;
      swd_out <= 1'b0; swd_oe <= 1'b0; reg_rd <= 1'b0; reg_wr <= 1'b0;
      reg_ap <= 1'b0; reg_addr <= '0; reg_wdata <= '0; err_sticky <= 1'b0;
    end else begin
      reg_rd <= 1'b0;
      reg_wr <= 1'b0;
      if (line_rst) begin
        st <= ST_RESET; locked <= 1'b1; low1 <= 1'b0;
        swd_oe <= 1'b0; swd_out <= 1'b0;
      end else begin
        case (st)
          ST_RESET: begin
            if (swd_in) low1 <= 1'b0;
            else if (low1) begin st <= ST_IDLE; low1 <= 1'b0; end
            else low1 <= 1'b1;
          end
          ST_IDLE: if (swd_in) begin
            st <= ST_REQ; rsh <= word[7:1]; bcnt <= CW'(1);
          end
          ST_REQ: begin
            rsh  <= word[7:1];
            bcnt <= bcnt + 1'b1;
            if (bcnt == CW'(7)) begin
              if (dec_ok) begin
                st <= ST_TRN_REQ; reg_ap <= dq.ap; reg_addr <= dq.addr;
                rnw_q <= dq.rnw; is_id <= id_hit; ack <= nxt_ack;
                reg_rd <= (nxt_ack == ACK_OK) && dq.rnw && !id_hit;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_TRN_REQ: begin
            st <= ST_ACK; swd_oe <= 1'b1; swd_out <= ack[0]; bcnt <= '0;
            dsh <= is_id ? {^ID_W, ID_W} : {^reg_rdata, reg_rdata};
          end
          ST_ACK: begin
            bcnt <= bcnt + 1'b1;
            if (bcnt == '0) swd_out <= ack[1];
            else if (bcnt == CW'(1)) swd_out <= ack[2];
            else begin
              bcnt <= '0;
              if (ack == ACK_OK && rnw_q) begin
                st <= ST_RDATA; swd_out <= dsh[0]; dsh <= dsh >> 1;
                if (is_id) locked <= 1'b0;
              end else if (ack == ACK_OK) begin
                st <= ST_TRN_WR; swd_oe <= 1'b0;
              end else begin
                st <= ST_TRN_END; swd_oe <= 1'b0;
              end
            end
          end
          ST_RDATA: begin
            bcnt <= bcnt + 1'b1;
            if (bcnt == LAST) begin
              st <= ST_TRN_END; swd_oe <= 1'b0;
            end else begin
              swd_out <= dsh[0]; dsh <= dsh >> 1;
            end
          end
          ST_TRN_WR: begin st <= ST_WDATA; bcnt <= '0; end
          ST_WDATA: begin
            dsh  <= wfull;
            bcnt <= bcnt + 1'b1;
            if (bcnt == LAST) begin
              st <= ST_IDLE;
              if (^wfull == 1'b0) begin
                reg_wr <= 1'b1; reg_wdata <= wfull[DW-1:0];
              end else begin
                err_sticky <= 1'b1;
              end
            end
          end
          ST_TRN_END: st <= ST_IDLE;
          default: st <= ST_RESET;
        endcase
      end
    end
  end

  assert_quiet_request_R4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE || st == ST_REQ || st == ST_RESET) |-> !swd_oe);
  assert_trn_release_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_TRN_REQ) |-> !swd_oe);
  assert_ack_driven_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ACK) |-> swd_oe);
  assert_relock_R2: assert property (@(posedge clk) disable iff (rst)
    line_rst |=> (locked && st == ST_RESET && !swd_oe));
  assert_locked_no_write_R6: assert property (@(posedge clk) disable iff (rst)
    reg_wr |-> !locked);
  assert_err_kept_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> !$fell(err_sticky));
  assert_strobes_apart_R8: assert property (@(posedge clk) disable iff (rst)
    !(reg_rd && reg_wr));
endmodule

// File: tb/sim_swd_target_engine.sv
module sim_swd_target_engine;
  localparam int CLK_P = 10;
  localparam logic [31:0] IDV = 32'h2BA01477;
  localparam logic [2:0] E_OK = 3'b001, E_WAIT = 3'b010, E_FAULT = 3'b100;

  logic clk = 1'b0, rst = 1'b1, host_en = 1'b1, host_bit = 1'b0, reg_ready = 1'b1;
  logic swd_in, swd_out, swd_oe, reg_rd, reg_wr, reg_ap, err_sticky;
  logic [1:0] reg_addr;
  logic [31:0] reg_rdata, reg_wdata;
  logic [31:0] bank [2][4];
  logic [31:0] shadow [2][4];
  int n_chk = 0, n_fail = 0;
  bit exp_locked = 1'b1;

  always #(CLK_P/2) clk = ~clk;

  assign swd_in = swd_oe ? swd_out : (host_en ? host_bit : 1'b1);
  assign reg_rdata = bank[reg_ap][reg_addr];
  always @(posedge clk) if (reg_wr) bank[reg_ap][reg_addr] <= reg_wdata;

  swd_target_engine u0 (
    .clk(clk), .rst(rst), .swd_in(swd_in), .swd_out(swd_out), .swd_oe(swd_oe),
    .reg_ready(reg_ready), .reg_rdata(reg_rdata), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_ap(reg_ap), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .err_sticky(err_sticky));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic period(input bit en, input bit v, output bit oe, output bit o);
    @(negedge clk);
    host_en = en; host_bit = v;
    #1; oe = swd_oe; o = swd_out;
  endtask

  function automatic bit is_id_rd(input bit ap, input bit rnw, input logic [1:0] a);
    return !ap && rnw && (a == 2'd0);
  endfunction

  function automatic logic [2:0] exp_ack(input bit lk, input bit ap, input bit rnw,
                                         input logic [1:0] a, input bit rdy);
    if (lk && !is_id_rd(ap, rnw, a)) return E_FAULT;
    if (!is_id_rd(ap, rnw, a) && !rdy) return E_WAIT;
    return E_OK;
  endfunction

  task automatic lows(input int n);
    bit oe, o;
    for (int i = 0; i < n; i++) period(1'b1, 1'b0, oe, o);
  endtask

  // corrupt: 0 none, 1 parity, 2 stop, 3 park
  task automatic txn(input bit ap, input bit rnw, input logic [1:0] a, input logic [31:0] wd,
                     input bit bad_wpar, input int corrupt);
    logic [7:0] rq; logic [2:0] ak, e; logic [32:0] rd;
    bit oe, o, strobe, any_oe;
    rq = {1'b1, 1'b0, ^{ap, rnw, a}, a[1], a[0], rnw, ap, 1'b1};
    if (corrupt == 1) rq[5] = ~rq[5];
    if (corrupt == 2) rq[6] = 1'b1;
    if (corrupt == 3) rq[7] = 1'b0;
    for (int i = 0; i < 8; i++) period(1'b1, rq[i], oe, o);
    if (corrupt != 0) begin
      any_oe = 1'b0;
      for (int i = 0; i < 8; i++) begin period(1'b1, 1'b0, oe, o); any_oe |= oe; end
      chk(!any_oe, "R4 bad request must get no response", 32'(any_oe), 32'd0);
      lows(4);
      return;
    end
    e = exp_ack(exp_locked, ap, rnw, a, reg_ready);
    period(1'b0, 1'b1, oe, o);
    strobe = reg_rd;
    chk(!oe, "R5 turnaround after request", 32'(oe), 32'd0);
    any_oe = 1'b1;
    for (int i = 0; i < 3; i++) begin period(1'b0, 1'b1, oe, o); ak[i] = o; any_oe &= oe; end
    chk(any_oe, "R5 acknowledge driven", 32'(any_oe), 32'd1);
    chk(ak == e, "R5 R6 R10 acknowledge code", 32'(ak), 32'(e));
    chk(strobe == (e == E_OK && rnw && !is_id_rd(ap, rnw, a)), "R7 R10 read strobe",
        32'(strobe), 32'(e == E_OK && rnw && !is_id_rd(ap, rnw, a)));
    if (e == E_OK && rnw) begin
      any_oe = 1'b1;
      for (int i = 0; i < 33; i++) begin period(1'b0, 1'b1, oe, o); rd[i] = o; any_oe &= oe; end
      chk(any_oe, "R7 data driven", 32'(any_oe), 32'd1);
      if (is_id_rd(ap, rnw, a)) begin
        chk(rd[31:0] == IDV, "R6 identification value", rd[31:0], IDV);
        exp_locked = 1'b0;
      end else begin
        chk(rd[31:0] == shadow[ap][a], "R7 read data", rd[31:0], shadow[ap][a]);
      end
      chk(rd[32] == ^rd[31:0], "R7 read parity", 32'(rd[32]), 32'(^rd[31:0]));
      period(1'b0, 1'b1, oe, o);
      chk(!oe, "R7 trailing turnaround", 32'(oe), 32'd0);
    end else if (e == E_OK) begin
      period(1'b0, 1'b1, oe, o);
      chk(!oe, "R8 turnaround before write data", 32'(oe), 32'd0);
      for (int i = 0; i < 32; i++) period(1'b1, wd[i], oe, o);
      period(1'b1, (^wd) ^ bad_wpar, oe, o);
      period(1'b1, 1'b0, oe, o);
      chk(reg_wr == !bad_wpar, "R8 R9 write strobe", 32'(reg_wr), 32'(!bad_wpar));
      if (!bad_wpar) begin
        chk(reg_wdata == wd && reg_addr == a && reg_ap == ap, "R8 write data", reg_wdata, wd);
        shadow[ap][a] = wd;
      end else begin
        chk(err_sticky, "R9 sticky error set", 32'(err_sticky), 32'd1);
      end
    end else begin
      period(1'b0, 1'b1, oe, o);
      chk(!oe, "R11 turnaround after WAIT/FAULT", 32'(oe), 32'd0);
      period(1'b1, 1'b0, oe, o);
      chk(!reg_wr && !oe, "R10 R11 no strobe, no data phase", 32'(reg_wr), 32'd0);
    end
    lows(2);
  endtask

  task automatic highs(input int n);
    bit oe, o;
    for (int i = 0; i < n; i++) period(1'b1, 1'b1, oe, o);
  endtask

  initial begin
    #(CLK_P * 150000);
    chk(1'b0, "watchdog expired", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit oe, o, any_oe;
    logic [7:0] idrq;
    void'($urandom(32'd20240607));
    for (int p = 0; p < 2; p++)
      for (int q = 0; q < 4; q++) begin bank[p][q] = '0; shadow[p][q] = '0; end
    repeat (3) @(negedge clk);
    chk(!swd_oe && !reg_rd && !reg_wr && !err_sticky, "R1 reset outputs",
        {swd_oe, reg_rd, reg_wr, err_sticky}, 32'd0);
    rst = 1'b0;
    @(negedge clk); #1;
    chk(!swd_oe && !err_sticky, "R1 first edge after reset", {swd_oe, err_sticky}, 32'd0);
    lows(2);
    // locked phase
    txn(1'b0, 1'b1, 2'd1, 32'd0, 1'b0, 0);
    txn(1'b1, 1'b0, 2'd2, 32'hDEADBEEF, 1'b0, 0);
    txn(1'b0, 1'b1, 2'd0, 32'd0, 1'b0, 0);
    // unlocked
    txn(1'b1, 1'b0, 2'd2, 32'hA5A5_0F0F, 1'b0, 0);
    txn(1'b1, 1'b1, 2'd2, 32'd0, 1'b0, 0);
    txn(1'b1, 1'b1, 2'd3, 32'd0, 1'b0, 1);
    txn(1'b0, 1'b1, 2'd1, 32'd0, 1'b0, 2);
    txn(1'b1, 1'b0, 2'd1, 32'd0, 1'b0, 3);
    reg_ready = 1'b0;
    txn(1'b1, 1'b1, 2'd2, 32'd0, 1'b0, 0);
    txn(1'b1, 1'b0, 2'd2, 32'h1234_5678, 1'b0, 0);
    txn(1'b0, 1'b1, 2'd0, 32'd0, 1'b0, 0);
    reg_ready = 1'b1;
    chk(!err_sticky, "R9 flag clear before bad write", 32'(err_sticky), 32'd0);
    txn(1'b1, 1'b0, 2'd1, 32'h0BAD_F00D, 1'b1, 0);
    // R2: 50 highs keep the link unlocked, 51 relock
    highs(50); lows(10);
    txn(1'b1, 1'b1, 2'd2, 32'd0, 1'b0, 0);
    highs(51); lows(10); exp_locked = 1'b1;
    txn(1'b1, 1'b1, 2'd2, 32'd0, 1'b0, 0);
    txn(1'b0, 1'b1, 2'd0, 32'd0, 1'b0, 0);
    // R3: a single low after line reset is not enough
    highs(51); exp_locked = 1'b1;
    lows(1);
    idrq = {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
    for (int i = 0; i < 8; i++) period(1'b1, idrq[i], oe, o);
    any_oe = 1'b0;
    for (int i = 0; i < 14; i++) begin period(1'b1, 1'b0, oe, o); any_oe |= oe; end
    chk(!any_oe, "R3 request ignored without two idle lows", 32'(any_oe), 32'd0);
    txn(1'b1, 1'b1, 2'd1, 32'd0, 1'b0, 0);
    txn(1'b0, 1'b1, 2'd0, 32'd0, 1'b0, 0);
    // constrained random traffic
    for (int n = 0; n < 80; n++) begin
      bit ap, rnw, bw;
      logic [1:0] a;
      ap = 1'($urandom); rnw = 1'($urandom); a = 2'($urandom);
      reg_ready = ($urandom % 4) != 0;
      bw = !rnw && (($urandom % 10) == 0);
      txn(ap, rnw, a, $urandom, bw, 0);
    end
    reg_ready = 1'b1;
    chk(err_sticky, "R9 flag still set", 32'(err_sticky), 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule